// File: doc/BRIEF.md
# Byte-masked double-rate SRAM write port

This block models the write side of a synchronous SRAM with split read and write ports. A write command is a fixed burst of two words. The first word and its lane mask are taken on the rising clock edge that sees the write select low. The second word and its own lane mask are taken on the falling edge half a cycle later. The data word is 36 bits, made of four 9-bit lanes. Each beat has an active-low enable per lane, and only the enabled lanes of that beat change the stored word.

The two words of a burst go to a pair of neighbouring locations. The burst base selects the pair, and the low address bit tells the first word (0) from the second (1). The storage is split by that low bit into an even bank and an odd bank, so each bank takes at most one write per cycle. Both words of a burst are written on the rising edge after the burst. A registered read port exposes the array so that its contents can be observed.

Top module: `qwp_top`

## Requirements
- R1: Lane i is data bits [9i+8:9i], for i from 0 to 3. Mask bit i (active low) of a beat controls lane i only.
- R2: A burst is accepted only when `wr_sel_n` is low at a rising edge. When it is high, neither beat of that cycle changes the array, whatever the masks show.
- R3: The first beat's data and mask are sampled at the accepting rising edge. Its word goes to address {`wr_base`, 0}.
- R4: The second beat's data and mask are sampled at the next falling edge. Its word goes to address {`wr_base`, 1}.
- R5: A beat whose mask is 4'hF writes nothing. The other beat of the same burst is still written according to its own mask.
- R6: Lanes whose mask bit is high keep their previous contents.
- R7: Both beats are committed at the rising edge after the accepting one. `rd_data` shows the word at the `rd_addr` sampled at a rising edge from that edge on. A read and a commit to the same word at the same edge return the old contents.
- R8: A new burst may be accepted on every rising edge, and all bursts in such a run are written.
- R9: A synchronous high `rst` drives `rd_data` to 0 and discards a burst that has been accepted but not yet committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge takes beat one, the falling edge takes beat two |
| rst | input | 1 | Synchronous reset, active high |
| wr_sel_n | input | 1 | Write select, active low, sampled at the rising edge |
| wr_base | input | 4 | Burst base address (the word address without its low bit) |
| wr_data | input | 36 | Beat data, four 9-bit lanes |
| wr_mask_n | input | 4 | Active-low lane enables for the beat being sampled |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 36 | Registered read data |

## Verification
A wrong lane gate, a swapped beat or a lost commit leaves a stored word corrupted. That word shows up on `rd_data` one rising edge after it is read. Commits land one edge after the burst, so a fault becomes visible two edges after the stimulus at the earliest, or later when the word is read back in a sweep. The reference model tracks every word and compares `rd_data` on every clock. Partial-lane, aborted-beat and idle-select bursts go to words with known contents, so any stray lane change shows up as a mismatch.

// File: rtl/qwp_pkg.sv
package qwp_pkg;
  parameter int QWP_LANE_W = 9;
  parameter int QWP_LANES  = 4;
  parameter int QWP_ADDR_W = 5;

  typedef enum logic {BEAT_EVEN = 1'b0, BEAT_ODD = 1'b1} beat_e;
endpackage

// File: rtl/qwp_beat_cap.sv
module qwp_beat_cap #(
  parameter int W       = 36,
  parameter int MW      = 4,
  parameter bit ON_FALL = 1'b0
) (
  input  logic          clk,
  input  logic [W-1:0]  d,
  input  logic [MW-1:0] m_n,
  output logic [W-1:0]  q,
  output logic [MW-1:0] qm_n
);
  generate
    if (ON_FALL) begin : g_fall
      always_ff @(negedge clk) begin
        q    <= d;
        qm_n <= m_n;
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        q    <= d;
        qm_n <= m_n;
      end
    end
  endgenerate
endmodule

// File: rtl/qwp_bank.sv
module qwp_bank #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  parameter int AW     = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANE_W*LANES-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANE_W*LANES-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] q_r;

      always_ff @(posedge clk) begin
        if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= mem[raddr];
      end

      assign rdata[g*LANE_W +: LANE_W] = q_r;
    end
  endgenerate
endmodule

// File: rtl/qwp_top.sv
module qwp_top
  import qwp_pkg::*;
#(
  parameter int LANE_W = QWP_LANE_W,
  parameter int LANES  = QWP_LANES,
  parameter int ADDR_W = QWP_ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_sel_n,
  input  logic [ADDR_W-2:0]       wr_base,
  input  logic [LANE_W*LANES-1:0] wr_data,
  input  logic [LANES-1:0]        wr_mask_n,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANE_W*LANES-1:0] rd_data
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int BASE_W = ADDR_W - 1;

  logic              cmt_vld;
  logic [BASE_W-1:0] cmt_base;
  logic [DATA_W-1:0] even_d, odd_d;
  logic [LANES-1:0]  even_m_n, odd_m_n;
  logic [LANES-1:0]  wen_even, wen_odd;
  logic [DATA_W-1:0] q_even, q_odd;
  beat_e             rd_sel;

  // command stage: accepted on the rising edge, committed on the next one
  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_vld <= 1'b0;
    end else begin
      cmt_vld <= ~wr_sel_n;
    end
    cmt_base <= wr_base;
  end

  qwp_beat_cap #(.W(DATA_W), .MW(LANES), .ON_FALL(1'b0)) u_cap_even (
    .clk (clk), .d (wr_data), .m_n (wr_mask_n), .q (even_d), .qm_n (even_m_n)
  );

  qwp_beat_cap #(.W(DATA_W), .MW(LANES), .ON_FALL(1'b1)) u_cap_odd (
    .clk (clk), .d (wr_data), .m_n (wr_mask_n), .q (odd_d), .qm_n (odd_m_n)
  );

  always_comb begin
    wen_even = {LANES{cmt_vld & ~rst}} & ~even_m_n;
    wen_odd  = {LANES{cmt_vld & ~rst}} & ~odd_m_n;
  end

  qwp_bank #(.LANE_W(LANE_W), .LANES(LANES), .AW(BASE_W)) u_bank_even (
    .clk (clk), .rst (rst), .we (wen_even), .waddr (cmt_base), .wdata (even_d),
    .raddr (rd_addr[ADDR_W-1:1]), .rdata (q_even)
  );

  qwp_bank #(.LANE_W(LANE_W), .LANES(LANES), .AW(BASE_W)) u_bank_odd (
    .clk (clk), .rst (rst), .we (wen_odd), .waddr (cmt_base), .wdata (odd_d),
    .raddr (rd_addr[ADDR_W-1:1]), .rdata (q_odd)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_sel <= BEAT_EVEN;
    else     rd_sel <= beat_e'(rd_addr[0]);
  end

  assign rd_data = (rd_sel == BEAT_ODD) ? q_odd : q_even;
endmodule

// File: rtl/qwp_chk.sv
module qwp_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_sel_n,
  input logic [LANES-1:0]  wr_mask_n,
  input logic [LANES-1:0]  wen_even,
  input logic [LANES-1:0]  wen_odd,
  input logic [DATA_W-1:0] rd_data
);
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_sel_n |=> (wen_even == '0 && wen_odd == '0)); // R2

  AST_EVEN_LANE_GATE: assert property (@(posedge clk) disable iff (rst)
    !wr_sel_n |=> (wen_even == ~$past(wr_mask_n))); // R3

  AST_EVEN_ABORT: assert property (@(posedge clk) disable iff (rst)
    (!wr_sel_n && (&wr_mask_n)) |=> (wen_even == '0)); // R5

  AST_ODD_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    (|wen_odd) |-> $past(!wr_sel_n)); // R4

  AST_RST_ZERO: assert property (@(posedge clk)
    rst |=> (rd_data == '0)); // R9
endmodule

bind qwp_top qwp_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
  .clk (clk), .rst (rst), .wr_sel_n (wr_sel_n), .wr_mask_n (wr_mask_n),
  .wen_even (wen_even), .wen_odd (wen_odd), .rd_data (rd_data)
);

// File: tb/sim_qwp_top.sv
`timescale 1ns/1ps
module sim_qwp_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_sel_n = 1'b1;
  logic [3:0]  wr_base = '0;
  logic [35:0] wr_data = '0;
  logic [3:0]  wr_mask_n = 4'hF;
  logic [4:0]  rd_addr = '0;
  logic [35:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string tag = "R9";

  always #2 clk = ~clk;

  qwp_top u0 (
    .clk (clk), .rst (rst), .wr_sel_n (wr_sel_n), .wr_base (wr_base),
    .wr_data (wr_data), .wr_mask_n (wr_mask_n), .rd_addr (rd_addr), .rd_data (rd_data)
  );

  // behavioural reference model
  logic [35:0] mdl [32];
  logic [35:0] exp_q;
  bit          pv = 1'b0;
  logic [3:0]  pa;
  logic [35:0] pd0, pd1;
  logic [3:0]  pm0, pm1;

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 'x;
  end

  always @(posedge clk) begin
    exp_q = rst ? 36'd0 : mdl[rd_addr];
    if (!rst && pv) begin
      for (int l = 0; l < 4; l++) begin
        if (!pm0[l]) mdl[{pa, 1'b0}][l*9 +: 9] = pd0[l*9 +: 9];
        if (!pm1[l]) mdl[{pa, 1'b1}][l*9 +: 9] = pd1[l*9 +: 9];
      end
    end
    pv  = !rst && !wr_sel_n;
    pa  = wr_base;
    pd0 = wr_data;
    pm0 = wr_mask_n;
  end

  always @(negedge clk) begin
    pd1 = wr_data;
    pm1 = wr_mask_n;
  end

  function automatic logic [35:0] pat(input int a, input int s);
    logic [35:0] v;
    for (int l = 0; l < 4; l++) v[l*9 +: 9] = 9'((a * 37 + s * 91 + l * 53 + 5) % 512);
    return v;
  endfunction

  // one clock: beat one set before the rising edge, beat two before the falling edge
  task automatic cyc(input logic wn, input logic [3:0] base,
                     input logic [35:0] d0, input logic [3:0] m0,
                     input logic [35:0] d1, input logic [3:0] m1,
                     input logic [4:0] ra);
    wr_sel_n  = wn;
    wr_base   = base;
    wr_data   = d0;
    wr_mask_n = m0;
    rd_addr   = ra;
    @(posedge clk);
    #1;
    if (!$isunknown(exp_q)) begin
      total++;
      if (rd_data !== exp_q) begin
        bad++;
        $display("FAIL %s rd_addr=%0d actual=%h expected=%h", tag, rd_addr, rd_data, exp_q);
      end
    end
    wr_data   = d1;
    wr_mask_n = m1;
    @(negedge clk);
    #1;
  endtask

  task automatic idle_read(input logic [4:0] ra);
    cyc(1'b1, 4'd0, '0, 4'hF, '0, 4'hF, ra);
  endtask

  task automatic sweep();
    for (int a = 0; a < 32; a++) idle_read(5'(a));
    idle_read(5'd0);
  endtask

  initial begin
    @(negedge clk); #1;
    tag = "R9";
    idle_read(5'd3);
    idle_read(5'd3);
    rst = 1'b0;

    // R8 R3 R4 R1: back-to-back full bursts fill every word
    tag = "R8";
    for (int b = 0; b < 16; b++)
      cyc(1'b0, 4'(b), pat(2*b, 1), 4'h0, pat(2*b+1, 1), 4'h0, 5'd0);
    idle_read(5'd0);
    tag = "R3";
    sweep();

    // R1 R6: one lane per beat, different lanes on each beat
    tag = "R6";
    for (int l = 0; l < 4; l++)
      cyc(1'b0, 4'(l + 2), pat(l, 7), ~(4'b1 << l), pat(l, 8), ~(4'b1 << ((l + 1) % 4)), 5'd0);
    cyc(1'b0, 4'd7, pat(9, 3), 4'b1010, pat(9, 4), 4'b0101, 5'd0);
    tag = "R1";
    sweep();

    // R5: aborted beat on one side only
    tag = "R5";
    cyc(1'b0, 4'd9, pat(1, 11), 4'hF, pat(2, 11), 4'h0, 5'd0);
    cyc(1'b0, 4'd10, pat(3, 11), 4'h0, pat(4, 11), 4'hF, 5'd0);
    cyc(1'b0, 4'd11, pat(5, 11), 4'hF, pat(6, 11), 4'hF, 5'd0);
    for (int a = 18; a < 24; a++) idle_read(5'(a));

    // R2: select high with all lanes enabled
    tag = "R2";
    cyc(1'b1, 4'd12, pat(7, 13), 4'h0, pat(8, 13), 4'h0, 5'd24);
    idle_read(5'd25);
    idle_read(5'd24);
    idle_read(5'd25);

    // R7: read the words being committed at the same edge, then again
    tag = "R7";
    cyc(1'b0, 4'd13, pat(1, 17), 4'h0, pat(2, 17), 4'h0, 5'd26);
    idle_read(5'd26);
    idle_read(5'd26);
    idle_read(5'd27);

    // R9: reset right after acceptance discards the burst
    tag = "R9";
    cyc(1'b0, 4'd14, pat(3, 19), 4'h0, pat(4, 19), 4'h0, 5'd28);
    rst = 1'b1;
    idle_read(5'd28);
    rst = 1'b0;
    idle_read(5'd28);
    idle_read(5'd29);
    idle_read(5'd29);

    tag = "R4";
    sweep();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog tag=%s actual=hung expected=finished", tag);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule